// File: doc/BRIEF.md
# Serial EEPROM Transaction Sequencer

This block turns one request for a whole memory-style transfer on a two-wire serial bus into the ordered list of bus primitives that a lower bit-level engine carries out. The primitives are: start condition, stop condition, send one byte and sample its acknowledge, and receive one byte and return an acknowledge. Three operations are supported. A presence probe checks whether a device answers. A write sends a device address, a register address and a payload. A read sends a device address, optionally a register address, and then a turnaround before the payload is read back.

Write payload bytes come in on a byte-wide valid/ready stream, and read bytes go out on another. At the end of each transfer the block posts a status code and, for writes, the number of payload bytes that the device refused. Some parts take part of the register address in the low bits of the device address. A fold mask copies those high register-address bits into the device-address field. A configuration bit picks how a read turns around between its address phase and its data phase.

Top module: `eeprom_txn_seq`

## Requirements
- R1: Operation code 0 is a probe: the engine receives start, send-byte {dev,0}, stop. Status is 0 (ok) when that byte was acknowledged and 1 (no device) when it was refused. Operation code 3 behaves as a probe.
- R2: For a write (code 1), or a read (code 2) with addr_len > 0, addr_len register-address bytes follow the write-mode device byte. They are sent most significant first, taken from reg_addr[8*addr_len-1:0].
- R3: The device field sent is dev | ((reg_addr >> 8*addr_len) & cfg_fold_mask). The shifted term is zero when addr_len equals the maximum address byte count.
- R4: A read with addr_len = 0 issues start and then send-byte {dev,1} directly, with no write-mode byte.
- R5: On a read with addr_len > 0, the turnaround after the last address byte is a start alone when cfg_rep_start = 1. It is a stop followed by a start when cfg_rep_start = 0.
- R6: A read of N bytes issues N receive-byte commands. eng_send_nack is 0 for all of them except the last, where it is 1. A stop follows. The bytes appear on rd_data in order, and each is held with rd_valid until rd_ready.
- R7: If the write-mode device byte of a write or read is refused, the block issues stop and ends with status 1. No write payload byte is taken.
- R8: If any register-address byte is refused, the block ends at once with status 2 (address error) and issues no stop.
- R9: During a write, a refused payload byte adds one to a failure count and the rest of the payload is still sent. A stop ends the write, fail_cnt reports the count, and status is 0.
- R10: The acknowledge of the read-mode device byte is ignored, and the read proceeds either way.
- R11: busy rises in the cycle after an accepted start and stays high until done. done is a one-cycle pulse in which busy is low. status and fail_cnt change only with done. A start while busy is ignored.
- R12: eng_req stays high, with eng_kind (0 start, 1 stop, 2 send byte, 3 receive byte), eng_byte and eng_send_nack stable, until eng_done. eng_req is low whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a transfer (taken when idle) |
| op | input | 2 | 0 probe, 1 write, 2 read |
| dev | input | 7 | Device address |
| reg_addr | input | 8*ADDR_BYTES | Register address |
| addr_len | input | AW | Register address bytes, 0..ADDR_BYTES |
| data_len | input | LEN_W | Payload byte count |
| cfg_fold_mask | input | 7 | Device bits that take high register-address bits |
| cfg_rep_start | input | 1 | Read turnaround: 1 start only, 0 stop then start |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte valid |
| wr_ready | output | 1 | Write payload byte taken |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | Read payload byte valid |
| rd_ready | input | 1 | Read payload byte accepted |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | 2 | 0 ok, 1 no device, 2 address error |
| fail_cnt | output | LEN_W | Refused write payload bytes |
| eng_req | output | 1 | Command to bit engine pending |
| eng_kind | output | 2 | Command kind |
| eng_byte | output | 8 | Byte to send |
| eng_send_nack | output | 1 | Refuse (1) or acknowledge (0) a received byte |
| eng_done | input | 1 | Engine finished the pending command |
| eng_nack | input | 1 | Sent byte was refused |
| eng_rdata | input | 8 | Received byte |

## Verification
A controller stuck in the wrong step shows up at the command port within one engine round trip. The next command popped from the expected list differs in kind or byte, or a command appears when none was expected, or the list is left non-empty at done. A wrong address index or remaining-length count shows as a misordered or extra address byte, or as the refuse flag landing on the wrong receive command. A miscounted failure tally or a wrong pending status appears only at done, on fail_cnt and status. An early or late stream handshake shows as a mismatched read byte, or as write bytes left unconsumed in the source.

// File: rtl/eeprom_txn_pkg.sv
package eeprom_txn_pkg;
  typedef enum logic [1:0] {OP_PROBE = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_RSVD = 2'd3} op_e;
  typedef enum logic [1:0] {CMD_START = 2'd0, CMD_STOP = 2'd1, CMD_SEND = 2'd2, CMD_RECV = 2'd3} cmd_e;
  typedef enum logic [1:0] {STAT_OK = 2'd0, STAT_NODEV = 2'd1, STAT_ADDR = 2'd2} stat_e;
  typedef enum logic [3:0] {
    S_IDLE, S_START1, S_DEVW, S_ADDR, S_MID, S_START2, S_DEVR,
    S_RDATA, S_RPUT, S_WGET, S_WDATA, S_STOP
  } state_e;
endpackage

// File: rtl/eeprom_txn_fold.sv
module eeprom_txn_fold #(
  parameter int ADDR_BYTES = 4,
  localparam int AW = $clog2(ADDR_BYTES + 1)
) (
  input  logic [6:0]              dev_in,
  input  logic [8*ADDR_BYTES-1:0] addr,
  input  logic [AW-1:0]           alen,
  input  logic [6:0]              mask,
  output logic [6:0]              dev_out
);
  logic [8*ADDR_BYTES-1:0] upper;

  always_comb begin
    upper = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (alen == AW'(i)) upper = addr >> (8 * i);
    end
    dev_out = dev_in | (upper[6:0] & mask);
  end
endmodule

// File: rtl/eeprom_txn_bytesel.sv
module eeprom_txn_bytesel #(
  parameter int ADDR_BYTES = 4,
  localparam int AW = $clog2(ADDR_BYTES + 1)
) (
  input  logic [8*ADDR_BYTES-1:0] addr,
  input  logic [AW-1:0]           idx,
  output logic [7:0]              byte_out
);
  always_comb begin
    byte_out = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (idx == AW'(i)) byte_out = addr[8*i +: 8];
    end
  end
endmodule

// File: rtl/eeprom_txn_cmdport.sv
module eeprom_txn_cmdport (
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  logic [1:0] kind_in,
  input  logic [7:0] byte_in,
  input  logic       nack_in,
  input  logic       eng_done,
  output logic       eng_req,
  output logic [1:0] eng_kind,
  output logic [7:0] eng_byte,
  output logic       eng_send_nack
);
  always_ff @(posedge clk) begin
    if (rst) begin
      eng_req       <= 1'b0;
      eng_kind      <= '0;
      eng_byte      <= '0;
      eng_send_nack <= 1'b0;
    end else if (issue) begin
      eng_req       <= 1'b1;
      eng_kind      <= kind_in;
      eng_byte      <= byte_in;
      eng_send_nack <= nack_in;
    end else if (eng_done) begin
      eng_req <= 1'b0;
    end
  end
endmodule

// File: rtl/eeprom_txn_seq.sv
module eeprom_txn_seq
  import eeprom_txn_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 8,
  localparam int AW = $clog2(ADDR_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [1:0]              op,
  input  logic [6:0]              dev,
  input  logic [8*ADDR_BYTES-1:0] reg_addr,
  input  logic [AW-1:0]           addr_len,
  input  logic [LEN_W-1:0]        data_len,
  input  logic [6:0]              cfg_fold_mask,
  input  logic                    cfg_rep_start,
  input  logic [7:0]              wr_data,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  output logic [7:0]              rd_data,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic                    busy,
  output logic                    done,
  output logic [1:0]              status,
  output logic [LEN_W-1:0]        fail_cnt,
  output logic                    eng_req,
  output logic [1:0]              eng_kind,
  output logic [7:0]              eng_byte,
  output logic                    eng_send_nack,
  input  logic                    eng_done,
  input  logic                    eng_nack,
  input  logic [7:0]              eng_rdata
);
  state_e              state, state_n;
  op_e                 op_q;
  logic [6:0]          dev_q, dev_fold;
  logic [8*ADDR_BYTES-1:0] addr_q;
  logic [AW-1:0]       alen_q, idx_q, sel_idx;
  logic [LEN_W-1:0]    rem_q, fail_q;
  logic                rep_q;
  stat_e               pend_q, fin_stat;
  logic [7:0]          addr_byte;

  logic       iss, iss_nack;
  cmd_e       iss_kind;
  logic [7:0] iss_byte;
  logic       fin, idx_dec, rem_dec, fail_inc, cap_rd, rd_take, set_nodev, accept;

  eeprom_txn_fold #(.ADDR_BYTES(ADDR_BYTES)) u_fold (
    .dev_in(dev), .addr(reg_addr), .alen(addr_len), .mask(cfg_fold_mask), .dev_out(dev_fold)
  );

  eeprom_txn_bytesel #(.ADDR_BYTES(ADDR_BYTES)) u_bytesel (
    .addr(addr_q), .idx(sel_idx), .byte_out(addr_byte)
  );

  eeprom_txn_cmdport u_cmd (
    .clk(clk), .rst(rst), .issue(iss), .kind_in(iss_kind), .byte_in(iss_byte),
    .nack_in(iss_nack), .eng_done(eng_done), .eng_req(eng_req), .eng_kind(eng_kind),
    .eng_byte(eng_byte), .eng_send_nack(eng_send_nack)
  );

  assign wr_ready = (state == S_WGET);
  assign accept   = (state == S_IDLE) && start;
  assign sel_idx  = (state == S_ADDR) ? idx_q - AW'(2) : idx_q - AW'(1);

  always_comb begin
    state_n   = state;
    iss       = 1'b0;
    iss_kind  = CMD_START;
    iss_byte  = 8'h00;
    iss_nack  = 1'b0;
    fin       = 1'b0;
    fin_stat  = pend_q;
    idx_dec   = 1'b0;
    rem_dec   = 1'b0;
    fail_inc  = 1'b0;
    cap_rd    = 1'b0;
    rd_take   = 1'b0;
    set_nodev = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        iss = 1'b1; iss_kind = CMD_START; state_n = S_START1;
      end
      S_START1: if (eng_done) begin
        iss = 1'b1; iss_kind = CMD_SEND;
        if (op_q == OP_READ && alen_q == '0) begin
          iss_byte = {dev_q, 1'b1}; state_n = S_DEVR;
        end else begin
          iss_byte = {dev_q, 1'b0}; state_n = S_DEVW;
        end
      end
      S_DEVW: if (eng_done) begin
        if (eng_nack || op_q == OP_PROBE || op_q == OP_RSVD) begin
          set_nodev = eng_nack;
          iss = 1'b1; iss_kind = CMD_STOP; state_n = S_STOP;
        end else if (alen_q != '0) begin
          iss = 1'b1; iss_kind = CMD_SEND; iss_byte = addr_byte; state_n = S_ADDR;
        end else if (rem_q == '0) begin
          iss = 1'b1; iss_kind = CMD_STOP; state_n = S_STOP;
        end else begin
          state_n = S_WGET;
        end
      end
      S_ADDR: if (eng_done) begin
        idx_dec = 1'b1;
        if (eng_nack) begin
          fin = 1'b1; fin_stat = STAT_ADDR; state_n = S_IDLE;
        end else if (idx_q > AW'(1)) begin
          iss = 1'b1; iss_kind = CMD_SEND; iss_byte = addr_byte;
        end else if (op_q == OP_WRITE) begin
          if (rem_q == '0) begin
            iss = 1'b1; iss_kind = CMD_STOP; state_n = S_STOP;
          end else begin
            state_n = S_WGET;
          end
        end else if (rep_q) begin
          iss = 1'b1; iss_kind = CMD_START; state_n = S_START2;
        end else begin
          iss = 1'b1; iss_kind = CMD_STOP; state_n = S_MID;
        end
      end
      S_MID: if (eng_done) begin
        iss = 1'b1; iss_kind = CMD_START; state_n = S_START2;
      end
      S_START2: if (eng_done) begin
        iss = 1'b1; iss_kind = CMD_SEND; iss_byte = {dev_q, 1'b1}; state_n = S_DEVR;
      end
      S_DEVR: if (eng_done) begin
        iss = 1'b1;
        if (rem_q == '0) begin
          iss_kind = CMD_STOP; state_n = S_STOP;
        end else begin
          iss_kind = CMD_RECV; iss_nack = (rem_q == LEN_W'(1)); state_n = S_RDATA;
        end
      end
      S_RDATA: if (eng_done) begin
        cap_rd = 1'b1; state_n = S_RPUT;
      end
      S_RPUT: if (rd_ready) begin
        rd_take = 1'b1; rem_dec = 1'b1; iss = 1'b1;
        if (rem_q == LEN_W'(1)) begin
          iss_kind = CMD_STOP; state_n = S_STOP;
        end else begin
          iss_kind = CMD_RECV; iss_nack = (rem_q == LEN_W'(2)); state_n = S_RDATA;
        end
      end
      S_WGET: if (wr_valid) begin
        iss = 1'b1; iss_kind = CMD_SEND; iss_byte = wr_data; state_n = S_WDATA;
      end
      S_WDATA: if (eng_done) begin
        rem_dec  = 1'b1;
        fail_inc = eng_nack;
        if (rem_q == LEN_W'(1)) begin
          iss = 1'b1; iss_kind = CMD_STOP; state_n = S_STOP;
        end else begin
          state_n = S_WGET;
        end
      end
      S_STOP: if (eng_done) begin
        fin = 1'b1; state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      op_q     <= OP_PROBE;
      dev_q    <= '0;
      addr_q   <= '0;
      alen_q   <= '0;
      idx_q    <= '0;
      rem_q    <= '0;
      fail_q   <= '0;
      rep_q    <= 1'b0;
      pend_q   <= STAT_OK;
      busy     <= 1'b0;
      done     <= 1'b0;
      status   <= STAT_OK;
      fail_cnt <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      state <= state_n;
      done  <= fin;
      if (accept) begin
        op_q   <= op_e'(op);
        dev_q  <= dev_fold;
        addr_q <= reg_addr;
        alen_q <= addr_len;
        idx_q  <= addr_len;
        rem_q  <= data_len;
        fail_q <= '0;
        rep_q  <= cfg_rep_start;
        pend_q <= STAT_OK;
        busy   <= 1'b1;
      end
      if (set_nodev) pend_q <= STAT_NODEV;
      if (idx_dec)   idx_q  <= idx_q - AW'(1);
      if (rem_dec)   rem_q  <= rem_q - LEN_W'(1);
      if (fail_inc)  fail_q <= fail_q + LEN_W'(1);
      if (cap_rd) begin
        rd_valid <= 1'b1;
        rd_data  <= eng_rdata;
      end
      if (rd_take) rd_valid <= 1'b0;
      if (fin) begin
        busy     <= 1'b0;
        status   <= fin_stat;
        fail_cnt <= fail_q;
      end
    end
  end
endmodule

// File: rtl/eeprom_txn_chk.sv
module eeprom_txn_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic [1:0]       status,
  input logic [LEN_W-1:0] fail_cnt,
  input logic             eng_req,
  input logic [1:0]       eng_kind,
  input logic [7:0]       eng_byte,
  input logic             eng_send_nack,
  input logic             eng_done,
  input logic             rd_valid,
  input logic [7:0]       rd_data,
  input logic             rd_ready,
  input logic             wr_ready
);
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_kind) && $stable(eng_byte) && $stable(eng_send_nack))); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!eng_req && !rd_valid && !wr_ready)); // R12

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(status) && $stable(fail_cnt))); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy ##1 !done); // R11

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R6
endmodule

bind eeprom_txn_seq eeprom_txn_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .status(status), .fail_cnt(fail_cnt),
  .eng_req(eng_req), .eng_kind(eng_kind), .eng_byte(eng_byte), .eng_send_nack(eng_send_nack),
  .eng_done(eng_done), .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
  .wr_ready(wr_ready)
);

// File: tb/test_eeprom_txn_seq.sv
module test_eeprom_txn_seq;
  localparam int AB = 4;
  localparam int AW = 3;
  localparam int LW = 8;
  localparam logic [1:0] K_START = 2'd0, K_STOP = 2'd1, K_SEND = 2'd2, K_RECV = 2'd3;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] op = '0;
  logic [6:0] dev = '0, cfg_fold_mask = '0;
  logic [31:0] reg_addr = '0;
  logic [AW-1:0] addr_len = '0;
  logic [LW-1:0] data_len = '0;
  logic cfg_rep_start = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, rd_ready = 1'b1;
  logic busy, done;
  logic [1:0] status;
  logic [LW-1:0] fail_cnt;
  logic eng_req, eng_send_nack;
  logic [1:0] eng_kind;
  logic [7:0] eng_byte;
  logic eng_done = 1'b0, eng_nack = 1'b0;
  logic [7:0] eng_rdata = '0;

  int errors = 0, checks = 0, cyc = 0;
  bit stall_en = 1'b0;
  string cur_tag = "R1";
  logic [10:0] exp_q[$];
  bit   nack_q[$];
  logic [7:0] rdat_q[$], rexp_q[$], src_q[$];

  always #2.5 clk = ~clk;

  eeprom_txn_seq #(.ADDR_BYTES(AB), .LEN_W(LW)) i_eeprom_txn_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .dev(dev), .reg_addr(reg_addr),
    .addr_len(addr_len), .data_len(data_len), .cfg_fold_mask(cfg_fold_mask),
    .cfg_rep_start(cfg_rep_start), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .busy(busy), .done(done),
    .status(status), .fail_cnt(fail_cnt), .eng_req(eng_req), .eng_kind(eng_kind),
    .eng_byte(eng_byte), .eng_send_nack(eng_send_nack), .eng_done(eng_done),
    .eng_nack(eng_nack), .eng_rdata(eng_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // engine model: compares each command against the expected list
  initial begin
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (eng_req) begin
        logic [10:0] got, want;
        got = {eng_kind, eng_byte, eng_send_nack};
        if (exp_q.size() == 0) begin
          chk(1'b0, {cur_tag, " unexpected command"}, got, 0);
        end else begin
          want = exp_q.pop_front();
          chk(got == want, {cur_tag, " command"}, got, want);
        end
        repeat (2) begin
          @(negedge clk);
          chk(eng_req && {eng_kind, eng_byte, eng_send_nack} == got, "R12 command held", {eng_kind, eng_byte}, got);
        end
        eng_nack = 1'b0;
        if (got[10:9] == K_SEND && nack_q.size() > 0) eng_nack = nack_q.pop_front();
        if (got[10:9] == K_RECV && rdat_q.size() > 0) eng_rdata = rdat_q.pop_front();
        eng_done = 1'b1;
      end
    end
  end

  // read stream monitor
  initial begin
    forever begin
      @(negedge clk);
      rd_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
      if (rd_valid && rd_ready) begin
        if (rexp_q.size() == 0) chk(1'b0, "R6 unexpected read byte", rd_data, 0);
        else begin
          logic [7:0] e;
          e = rexp_q.pop_front();
          chk(rd_data == e, "R6 read byte", rd_data, e);
        end
      end
    end
  end

  // write stream source
  initial begin
    bit hs = 1'b0;
    forever begin
      @(negedge clk);
      if (hs && src_q.size() > 0) void'(src_q.pop_front());
      wr_valid = src_q.size() > 0;
      wr_data  = wr_valid ? src_q[0] : 8'h00;
      hs = wr_valid && wr_ready;
    end
  end

  function automatic logic [10:0] cmd(input logic [1:0] k, input logic [7:0] b, input bit n);
    return {k, b, n};
  endfunction

  task automatic txn(input int opc, input logic [6:0] ch, input logic [31:0] ad, input int al,
                     input int dl, input logic [6:0] mk, input bit rep, input bit nch, input int nad,
                     input logic [31:0] ndat, input bit nrch, input logic [7:0] base, input bit poke,
                     input string tag);
    logic [6:0] fch;
    logic [31:0] hi;
    int est = 0, efail = 0, eleft = 0;
    cur_tag = tag;
    hi  = (al >= AB) ? 32'h0 : (ad >> (8 * al));
    fch = ch | (hi[6:0] & mk);
    exp_q.delete(); nack_q.delete(); rdat_q.delete(); rexp_q.delete(); src_q.delete();
    exp_q.push_back(cmd(K_START, 8'h00, 0));
    if (opc == 1) for (int j = 0; j < dl; j++) src_q.push_back(8'(base + j * 17));
    if (opc == 2 && al == 0) begin
      exp_q.push_back(cmd(K_SEND, {fch, 1'b1}, 0)); nack_q.push_back(nrch);
    end else begin
      exp_q.push_back(cmd(K_SEND, {fch, 1'b0}, 0)); nack_q.push_back(nch);
    end
    if (!(opc == 2 && al == 0)) begin
      if (nch) begin
        exp_q.push_back(cmd(K_STOP, 8'h00, 0)); est = 1; eleft = (opc == 1) ? dl : 0;
      end else if (opc == 0 || opc == 3) begin
        exp_q.push_back(cmd(K_STOP, 8'h00, 0));
      end else begin
        for (int i = al - 1; i >= 0 && est == 0; i--) begin
          exp_q.push_back(cmd(K_SEND, 8'(ad >> (8 * i)), 0));
          nack_q.push_back(i == nad);
          if (i == nad) begin est = 2; eleft = (opc == 1) ? dl : 0; end
        end
        if (est == 0 && opc == 1) begin
          for (int j = 0; j < dl; j++) begin
            exp_q.push_back(cmd(K_SEND, 8'(base + j * 17), 0));
            nack_q.push_back(ndat[j]);
            efail += int'(ndat[j]);
          end
          exp_q.push_back(cmd(K_STOP, 8'h00, 0));
        end
        if (est == 0 && opc == 2) begin
          if (!rep) exp_q.push_back(cmd(K_STOP, 8'h00, 0));
          exp_q.push_back(cmd(K_START, 8'h00, 0));
          exp_q.push_back(cmd(K_SEND, {fch, 1'b1}, 0)); nack_q.push_back(nrch);
        end
      end
    end
    if (opc == 2 && est == 0) begin
      for (int j = 0; j < dl; j++) begin
        exp_q.push_back(cmd(K_RECV, 8'h00, j == dl - 1));
        rdat_q.push_back(8'(base ^ (j * 29)));
        rexp_q.push_back(8'(base ^ (j * 29)));
      end
      exp_q.push_back(cmd(K_STOP, 8'h00, 0));
    end
    @(negedge clk);
    start = 1'b1; op = 2'(opc); dev = ch; reg_addr = ad; addr_len = AW'(al);
    data_len = LW'(dl); cfg_fold_mask = mk; cfg_rep_start = rep;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; op = 2'd0; dev = 7'h11; addr_len = '0;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R11 busy low at done", busy, 0);
    chk(status == 2'(est), {tag, " status"}, status, est);
    chk(fail_cnt == LW'(efail), {tag, " fail count"}, fail_cnt, efail);
    chk(exp_q.size() == 0, {tag, " commands left"}, exp_q.size(), 0);
    chk(rexp_q.size() == 0, {tag, " read bytes left"}, rexp_q.size(), 0);
    chk(src_q.size() == eleft, {tag, " write bytes left"}, src_q.size(), eleft);
    repeat (2) @(negedge clk);
    chk(status == 2'(est) && !eng_req, "R11 result held", status, est);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !eng_req && !rd_valid, "R11 reset idle", {busy, done, eng_req, rd_valid}, 0);
    chk(status == 2'd0 && fail_cnt == '0, "R11 reset result", status, 0);
    //  op ch     addr          al dl mask  rep nch nad ndat        nrch base poke
    txn(0, 7'h50, 32'h0,        0, 0, 7'h0, 0,  0,  -1, 32'h0,       0,  8'h00, 0, "R1");
    txn(0, 7'h51, 32'h0,        0, 0, 7'h0, 0,  1,  -1, 32'h0,       0,  8'h00, 0, "R1");
    txn(3, 7'h22, 32'h0,        0, 0, 7'h0, 0,  0,  -1, 32'h0,       0,  8'h00, 0, "R1");
    txn(1, 7'h50, 32'h1234,     2, 3, 7'h0, 0,  0,  -1, 32'h0,       0,  8'h30, 0, "R2");
    txn(1, 7'h50, 32'hA1B2C3D4, 4, 1, 7'h7, 0,  0,  -1, 32'h0,       0,  8'h44, 0, "R2");
    txn(1, 7'h50, 32'h345,      1, 2, 7'h7, 0,  0,  -1, 32'h0,       0,  8'h10, 0, "R3");
    txn(2, 7'h48, 32'h3FF,      0, 2, 7'h3, 0,  0,  -1, 32'h0,       0,  8'h77, 0, "R3");
    txn(1, 7'h50, 32'h0,        0, 4, 7'h0, 0,  0,  -1, 32'h5,       0,  8'h90, 0, "R9");
    txn(1, 7'h50, 32'h77,       1, 3, 7'h0, 0,  0,  -1, 32'h7,       0,  8'h05, 1, "R9");
    txn(1, 7'h52, 32'h12,       1, 3, 7'h0, 0,  1,  -1, 32'h0,       0,  8'h01, 0, "R7");
    txn(2, 7'h52, 32'h12,       1, 3, 7'h0, 0,  1,  -1, 32'h0,       0,  8'h01, 0, "R7");
    txn(1, 7'h50, 32'h123456,   3, 2, 7'h0, 0,  0,  1,  32'h0,       0,  8'h02, 0, "R8");
    txn(2, 7'h50, 32'h9876,     2, 2, 7'h0, 1,  0,  0,  32'h0,       0,  8'h02, 0, "R8");
    stall_en = 1'b1;
    txn(2, 7'h50, 32'h0,        0, 3, 7'h0, 0,  0,  -1, 32'h0,       0,  8'h5A, 0, "R4");
    txn(2, 7'h50, 32'h40,       1, 2, 7'h0, 0,  0,  -1, 32'h0,       0,  8'hC3, 0, "R5");
    txn(2, 7'h50, 32'h0102,     2, 2, 7'h0, 1,  0,  -1, 32'h0,       0,  8'h3C, 1, "R5");
    txn(2, 7'h50, 32'h08,       1, 1, 7'h0, 0,  0,  -1, 32'h0,       0,  8'hEE, 0, "R6");
    txn(2, 7'h50, 32'h08,       1, 2, 7'h0, 1,  0,  -1, 32'h0,       1,  8'h66, 0, "R10");
    txn(2, 7'h50, 32'h0,        0, 0, 7'h0, 0,  0,  -1, 32'h0,       1,  8'h00, 0, "R10");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule